// File: doc/BRIEF.md
# Bitfield Clear, Insert and Extract Unit

This unit sits in the execute stage of a 32-bit integer pipeline. It handles four bitfield operations chosen by a 2-bit operation code. Clear zeroes a contiguous field of the destination's current value. Insert copies the low bits of a source operand into such a field and leaves the other destination bits as they were. Signed extract and unsigned extract pull a field out of the source and right-justify it, with sign fill or zero fill.

The field's low bit position is given in two pieces, a 3-bit upper part and a 2-bit lower part. A second 5-bit field has one of two meanings. For clear and insert it is the field's top bit position. For the two extracts it is the field width minus one. The unit also checks the field range and the register indices. A request that is out of range, or that names register 15 where that is not allowed, is reported as unpredictable and causes no write. The result is registered, so it appears one cycle after the request.

Top module: `bf_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `res_data` is 0 and `res_we` and `res_unpred` are 0.
- R2: The low bit position is `{lsb_hi, lsb_lo}`, with `lsb_hi` as bits 4:2 and `lsb_lo` as bits 1:0.
- R3: Operation code 0 (clear) gives the destination value with bits `fld` down to the low bit position forced to 0. The source index plays no part in the checks for this operation.
- R4: Operation code 1 (insert) keeps the destination bits outside `fld` down to the low bit position. Inside that range it places the source shifted left by the low bit position.
- R5: Operation code 2 (signed extract) returns source bits [lsb+fld : lsb], right-justified and sign-extended from the field's top bit.
- R6: Operation code 3 (unsigned extract) returns source bits [lsb+fld : lsb], right-justified and zero-extended.
- R7: For clear and insert, `fld` below the low bit position is unpredictable.
- R8: For both extracts, a low bit position plus `fld` of 32 or more is unpredictable. A sum of exactly 31 is legal.
- R9: A destination index of 15 is unpredictable for every operation. A source index of 15 is unpredictable for insert and both extracts.
- R10: An unpredictable request gives `res_unpred`=1, `res_we`=0 and `res_data`=0. A legal request gives `res_we`=1 and `res_unpred`=0.
- R11: A field width of 32 is handled without overflow: an insert or unsigned extract over bits 31..0 yields the source, and a clear over bits 31..0 yields 0.
- R12: The result appears at the clock edge that samples `in_valid`=1. A cycle with `in_valid`=0 gives `res_we`=0, `res_unpred`=0 and `res_data`=0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| op | input | 2 | 0 clear, 1 insert, 2 signed extract, 3 unsigned extract |
| dst_idx | input | 4 | Destination register index |
| src_idx | input | 4 | Source register index |
| dst_val | input | 32 | Current destination value |
| src_val | input | 32 | Source operand value |
| lsb_hi | input | 3 | Upper three bits of the low bit position |
| lsb_lo | input | 2 | Lower two bits of the low bit position |
| fld | input | 5 | Top bit (clear/insert) or width minus one (extract) |
| res_data | output | 32 | Result, zero when no write |
| res_we | output | 1 | Write enable for the result |
| res_unpred | output | 1 | Request was unpredictable |

## Verification
A range violation and a forbidden register index can occur in the same request. The bench provokes this in two ways: an insert whose top bit is below its low bit while the destination index is 15, and an unsigned extract that runs past bit 31 while the source index is 15. In both cases the one outcome that counts as correct is a single unpredictable report with no write and a zero result. The bench also sends a legal clear with source index 15, to show that the index check does not fire where the operation ignores the source.

// File: rtl/bf_pkg.sv
package bf_pkg;

    localparam int BF_W     = 32;
    localparam int BF_POS_W = 5;
    localparam int BF_SH_W  = BF_POS_W + 1;
    localparam int BF_IDX_W = 4;

    typedef enum logic [1:0] {
        BF_CLEAR  = 2'd0,
        BF_INSERT = 2'd1,
        BF_SEXT   = 2'd2,
        BF_UEXT   = 2'd3
    } bf_op_e;

    typedef struct packed {
        bf_op_e                op;
        logic [BF_W-1:0]       dst_val;
        logic [BF_W-1:0]       src_val;
        logic [BF_POS_W-1:0]   lsb;
        logic [BF_POS_W-1:0]   fld;
    } bf_req_t;

    typedef struct packed {
        logic            range_bad;
        logic            idx_bad;
    } bf_chk_t;

    function automatic logic uses_source(bf_op_e o);
        return o != BF_CLEAR;
    endfunction

    function automatic logic is_extract(bf_op_e o);
        return (o == BF_SEXT) || (o == BF_UEXT);
    endfunction

endpackage

// File: rtl/bf_mask_gen.sv
module bf_mask_gen #(
    parameter int W    = 32,
    parameter int SH_W = 6
) (
    input  logic [SH_W-1:0]   width,
    input  logic [SH_W-2:0]   shift,
    output logic [W-1:0]      mask
);
    logic [W-1:0] ones;

    always_comb begin
        if (int'(width) >= W) ones = '1;
        else                  ones = ~({W{1'b1}} << width);
        mask = ones << shift;
    end
endmodule

// File: rtl/bf_guard.sv
module bf_guard
    import bf_pkg::*;
#(
    parameter int IDX_W  = BF_IDX_W,
    parameter int PC_IDX = 15
) (
    input  bf_op_e                op,
    input  logic [IDX_W-1:0]      dst_idx,
    input  logic [IDX_W-1:0]      src_idx,
    input  logic [BF_POS_W-1:0]   lsb,
    input  logic [BF_POS_W-1:0]   fld,
    output bf_chk_t               chk
);
    localparam logic [IDX_W-1:0] PC_V = IDX_W'(PC_IDX);

    logic [BF_SH_W-1:0] top_bit;

    always_comb begin
        top_bit       = {1'b0, lsb} + {1'b0, fld};
        if (is_extract(op))
            chk.range_bad = top_bit >= BF_SH_W'(BF_W);
        else
            chk.range_bad = fld < lsb;
        chk.idx_bad   = (dst_idx == PC_V) ||
                        (uses_source(op) && (src_idx == PC_V));
    end
endmodule

// File: rtl/bf_datapath.sv
module bf_datapath
    import bf_pkg::*;
(
    input  bf_req_t           req,
    output logic [BF_W-1:0]   res
);
    logic [BF_SH_W-1:0] fwidth;
    logic [BF_SH_W-1:0] xwidth;
    logic [BF_SH_W-1:0] lsh;
    logic [BF_SH_W-1:0] rsh;
    logic [BF_W-1:0]    fmask;
    logic [BF_W-1:0]    xmask;
    logic [BF_W-1:0]    sx_tmp;

    assign fwidth = {1'b0, req.fld} - {1'b0, req.lsb} + BF_SH_W'(1);
    assign xwidth = {1'b0, req.fld} + BF_SH_W'(1);

    bf_mask_gen #(.W(BF_W), .SH_W(BF_SH_W)) u_fmask (
        .width (fwidth),
        .shift (req.lsb),
        .mask  (fmask)
    );

    bf_mask_gen #(.W(BF_W), .SH_W(BF_SH_W)) u_xmask (
        .width (xwidth),
        .shift ('0),
        .mask  (xmask)
    );

    always_comb begin
        lsh    = BF_SH_W'(BF_W) - xwidth - {1'b0, req.lsb};
        rsh    = BF_SH_W'(BF_W) - xwidth;
        sx_tmp = req.src_val << lsh;
        unique case (req.op)
            BF_CLEAR:  res = req.dst_val & ~fmask;
            BF_INSERT: res = (req.dst_val & ~fmask) |
                             ((req.src_val << req.lsb) & fmask);
            BF_SEXT:   res = $unsigned($signed(sx_tmp) >>> rsh);
            default:   res = (req.src_val >> req.lsb) & xmask;
        endcase
    end
endmodule

// File: rtl/bf_unit.sv
module bf_unit
    import bf_pkg::*;
#(
    parameter int IDX_W  = BF_IDX_W,
    parameter int PC_IDX = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           op,
    input  logic [IDX_W-1:0]     dst_idx,
    input  logic [IDX_W-1:0]     src_idx,
    input  logic [BF_W-1:0]      dst_val,
    input  logic [BF_W-1:0]      src_val,
    input  logic [2:0]           lsb_hi,
    input  logic [1:0]           lsb_lo,
    input  logic [BF_POS_W-1:0]  fld,
    output logic [BF_W-1:0]      res_data,
    output logic                 res_we,
    output logic                 res_unpred
);
    localparam logic [IDX_W-1:0] PC_V = IDX_W'(PC_IDX);

    bf_req_t         req;
    bf_chk_t         chk;
    logic [BF_W-1:0] dp_res;
    logic            bad;

    always_comb begin
        req.op      = bf_op_e'(op);
        req.dst_val = dst_val;
        req.src_val = src_val;
        req.lsb     = {lsb_hi, lsb_lo};
        req.fld     = fld;
    end

    bf_guard #(.IDX_W(IDX_W), .PC_IDX(PC_IDX)) u_guard (
        .op      (req.op),
        .dst_idx (dst_idx),
        .src_idx (src_idx),
        .lsb     (req.lsb),
        .fld     (req.fld),
        .chk     (chk)
    );

    bf_datapath u_dp (
        .req (req),
        .res (dp_res)
    );

    assign bad = chk.range_bad | chk.idx_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_data   <= '0;
            res_we     <= 1'b0;
            res_unpred <= 1'b0;
        end else if (in_valid) begin
            res_data   <= bad ? '0 : dp_res;
            res_we     <= ~bad;
            res_unpred <= bad;
        end else begin
            res_data   <= '0;
            res_we     <= 1'b0;
            res_unpred <= 1'b0;
        end
    end

    AST_UNPRED_SILENT: assert property (@(posedge clk) disable iff (rst)
        res_unpred |-> (!res_we && res_data == '0)); // R10

    AST_DEST_PC_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dst_idx == PC_V) |=> res_unpred); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!in_valid) |=> (!res_we && !res_unpred)); // R12

    AST_VALID_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (res_we ^ res_unpred)); // R10

    AST_FULL_EXTRACT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd3 && lsb_hi == 3'd0 && lsb_lo == 2'd0 &&
         fld == 5'd31 && dst_idx != PC_V && src_idx != PC_V)
        |=> (res_we && res_data == $past(src_val))); // R11

    AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd0 && lsb_hi == 3'd0 && lsb_lo == 2'd0 &&
         fld == 5'd31 && dst_idx != PC_V)
        |=> (res_we && res_data == '0)); // R11
endmodule

// File: tb/tb_bf_unit.sv
`timescale 1ns/1ps
module tb_bf_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op;
    logic [3:0]  dst_idx, src_idx;
    logic [31:0] dst_val, src_val;
    logic [2:0]  lsb_hi;
    logic [1:0]  lsb_lo;
    logic [4:0]  fld;
    logic [31:0] res_data;
    logic        res_we, res_unpred;

    int total = 0;
    int bad_n = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    bf_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .dst_idx(dst_idx), .src_idx(src_idx), .dst_val(dst_val),
        .src_val(src_val), .lsb_hi(lsb_hi), .lsb_lo(lsb_lo), .fld(fld),
        .res_data(res_data), .res_we(res_we), .res_unpred(res_unpred)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad_n++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Independent bit-by-bit reference.
    task automatic model(input logic [1:0] o, input logic [3:0] di, input logic [3:0] si,
                         input logic [31:0] d, input logic [31:0] s,
                         input int lsb, input int f,
                         output logic [31:0] r, output logic unp);
        int w;
        r   = 0;
        unp = (di == 4'd15) || (o != 2'd0 && si == 4'd15);
        if (o <= 2'd1) begin
            if (f < lsb) unp = 1'b1;
            r = d;
            for (int i = lsb; i <= f; i++) r[i] = (o == 2'd0) ? 1'b0 : s[i-lsb];
        end else begin
            if (lsb + f >= 32) unp = 1'b1;
            w = f + 1;
            for (int i = 0; i < 32; i++) begin
                if (i < w && lsb + i < 32) r[i] = s[lsb+i];
                else if (i >= w && o == 2'd2 && lsb + w - 1 < 32) r[i] = s[lsb+w-1];
                else r[i] = 1'b0;
            end
        end
        if (unp) r = 0;
    endtask

    task automatic run(string req, logic [1:0] o, logic [3:0] di, logic [3:0] si,
                       logic [31:0] d, logic [31:0] s, int lsb, int f);
        logic [31:0] er;
        logic        eu;
        model(o, di, si, d, s, lsb, f, er, eu);
        @(negedge clk);
        in_valid = 1'b1; op = o; dst_idx = di; src_idx = si;
        dst_val = d; src_val = s;
        lsb_hi = 3'(lsb >> 2); lsb_lo = 2'(lsb & 3); fld = 5'(f);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " data"}, res_data, er);
        chk({req, " we"}, {31'd0, res_we}, {31'd0, ~eu});
        chk({req, " unpred"}, {31'd0, res_unpred}, {31'd0, eu});
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 data", res_data, 32'd0);
        chk("R1 we", {31'd0, res_we}, 32'd0);
        chk("R1 unpred", {31'd0, res_unpred}, 32'd0);
    endtask

    task automatic t_clear;
        run("R3 R2 clear 14..20", 2'd0, 4'd1, 4'd2, 32'hFFFF_FFFF, 32'h0, 14, 20);
        run("R3 clear single bit 7", 2'd0, 4'd3, 4'd4, 32'h0000_00F0, 32'h0, 7, 7);
        run("R3 clear src idx 15 ignored", 2'd0, 4'd5, 4'd15, 32'hDEAD_BEEF, 32'h1, 4, 11);
    endtask

    task automatic t_insert;
        run("R4 insert 8..15", 2'd1, 4'd1, 4'd2, 32'h1234_5678, 32'h0000_00AB, 8, 15);
        run("R4 R2 insert 29..31", 2'd1, 4'd1, 4'd2, 32'h0000_0000, 32'hFFFF_FFFD, 29, 31);
    endtask

    task automatic t_extract;
        run("R5 sext negative", 2'd2, 4'd1, 4'd2, 32'h0, 32'h0000_0F00, 8, 3);
        run("R5 sext positive", 2'd2, 4'd1, 4'd2, 32'h0, 32'h0000_0700, 8, 3);
        run("R5 sext top field", 2'd2, 4'd1, 4'd2, 32'h0, 32'h8000_0000, 31, 0);
        run("R6 uext mid", 2'd3, 4'd1, 4'd2, 32'h0, 32'hCAFE_F00D, 12, 7);
        run("R6 R8 uext ends at bit 31", 2'd3, 4'd1, 4'd2, 32'h0, 32'hF000_0000, 16, 15);
    endtask

    task automatic t_full;
        run("R11 insert full", 2'd1, 4'd1, 4'd2, 32'h1111_1111, 32'hA5A5_5A5A, 0, 31);
        run("R11 uext full", 2'd3, 4'd1, 4'd2, 32'h0, 32'h8765_4321, 0, 31);
        run("R11 sext full", 2'd2, 4'd1, 4'd2, 32'h0, 32'h8765_4321, 0, 31);
        run("R11 clear full", 2'd0, 4'd1, 4'd2, 32'hFFFF_FFFF, 32'h0, 0, 31);
    endtask

    task automatic t_range;
        run("R7 clear msb below lsb", 2'd0, 4'd1, 4'd2, 32'hFFFF_FFFF, 32'h0, 31, 30);
        run("R7 insert msb below lsb", 2'd1, 4'd1, 4'd2, 32'hFFFF_FFFF, 32'h3, 5, 4);
        run("R8 uext past 31", 2'd3, 4'd1, 4'd2, 32'h0, 32'hFFFF_FFFF, 16, 16);
        run("R8 sext past 31", 2'd2, 4'd1, 4'd2, 32'h0, 32'hFFFF_FFFF, 31, 1);
    endtask

    task automatic t_index;
        run("R9 dst 15 clear", 2'd0, 4'd15, 4'd2, 32'hFFFF_FFFF, 32'h0, 0, 3);
        run("R9 src 15 insert", 2'd1, 4'd1, 4'd15, 32'h0, 32'hF, 0, 3);
        run("R9 src 15 sext", 2'd2, 4'd1, 4'd15, 32'h0, 32'hF, 0, 3);
    endtask

    task automatic t_collide;
        run("R10 range and dst 15", 2'd1, 4'd15, 4'd2, 32'hFFFF_FFFF, 32'hF, 9, 2);
        run("R10 range and src 15", 2'd3, 4'd1, 4'd15, 32'h0, 32'hFFFF_FFFF, 28, 8);
    endtask

    task automatic t_idle;
        run("R12 setup write", 2'd3, 4'd1, 4'd2, 32'h0, 32'hFFFF_FFFF, 0, 7);
        @(negedge clk);
        op = 2'd1; dst_idx = 4'd15; src_val = 32'hFFFF_FFFF; fld = 5'd31;
        @(negedge clk);
        chk("R12 idle data", res_data, 32'd0);
        chk("R12 idle we", {31'd0, res_we}, 32'd0);
        chk("R12 idle unpred", {31'd0, res_unpred}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = 2'd0; dst_idx = 4'd0; src_idx = 4'd0;
        dst_val = 32'd0; src_val = 32'd0; lsb_hi = 3'd0; lsb_lo = 2'd0; fld = 5'd0;
        repeat (3) @(negedge clk);
        chk("R1 data in reset", res_data, 32'd0);
        rst = 1'b0;
        t_reset;
        t_clear;
        t_insert;
        t_extract;
        t_full;
        t_range;
        t_index;
        t_collide;
        t_idle;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad_n);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            total++;
            bad_n++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad_n);
            $finish;
        end
    end
endmodule